// File: doc/BRIEF.md
# Partial Reconfiguration Session Sequencer

This block runs one partial-reconfiguration session against a device configuration port. A pulse on `start_i` makes it screen the request: the session must be partial, the mode-select pins must show one of the two passive-parallel settings, and the sensed nconfig and nstatus pin levels must both be high. If any of these fails, it reports at once and never touches the port. Otherwise it takes the port: chip enable goes low, the configuration clock and data path are enabled, and the override is claimed. It then sends a flush burst of configuration clocks, raises the PR request, sends a long burst of clocks, and polls for the ready handshake.

While the external streamer moves the payload, the block waits for an end-of-data indication. It then polls for the done handshake. From either poll, the error input aborts the session and an exhausted poll budget also aborts it. Every session that got past screening then runs the same teardown: it drops the request, sends another flush burst, turns off the path, raises chip enable and releases the override. Only after that does it check the final device status and present a two-bit result with a one-cycle done pulse.

Configuration clocks are a divided enable from the system clock: one high cycle per counted clock, every `DIV` cycles, and low outside bursts.

Top module: `prseq_top`

## Requirements
- R1: With `partial_i` low at start, no session begins. `done_o` is high in the cycle after the start edge, `result_o` is 1 (invalid), and the port outputs stay idle: `nce_o` 1, the others 0.
- R2: A `msel_i` value other than 3'b000 or 3'b001 at start is rejected with result 1 in the same way as R1. Both 3'b000 and 3'b001 are accepted.
- R3: If `nconfig_pin_i` or `nstatus_pin_i` is low at start, the request is rejected with result 1 in the same way as R1.
- R4: An accepted start drives `nce_o` to 0 and `path_en_o` and `override_o` to 1 from the next cycle. The block then sends FLUSH_CLKS (256) pulses on `dclk_o` with `pr_request_o` low. Each pulse is one cycle high followed by DIV-1 low cycles.
- R5: After the flush, `pr_request_o` rises and REQ_CLKS (2047) further pulses follow before any polling.
- R6: The ready poll checks once per cycle. `pr_error_i` takes priority and aborts with result 2. `pr_ready_i` moves the session to streaming. After POLL_MAX (10) checks with neither input, the session aborts with result 3.
- R7: In streaming, the block waits for `data_end_i` and ignores the handshake inputs. It then polls `pr_done_i` under the same rules and budget as R6.
- R8: Teardown runs after success and after every abort, in this order: `pr_request_o` low with a FLUSH_CLKS burst; then `path_en_o` low for one cycle; then `nce_o` high for one cycle; then `override_o` low for the status check.
- R9: In the check cycle after teardown, the result is 0 only if no abort occurred and `usermode_i`, `conf_done_pin_i` and `nstatus_pin_i` are all high. A session with no abort but a failed status reports 3. An abort keeps its own code.
- R10: `done_o` is a single-cycle pulse. `result_o` changes only in a `done_o` cycle and holds until the next report. `busy_o` is high from the cycle after an accepted or rejected start through the done cycle. Reset state: `nce_o` 1, all other outputs 0.
- R11: `dclk_o` is low whenever no burst is running. `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Session start request |
| partial_i | input | 1 | 1 = partial session requested, 0 = full configuration |
| msel_i | input | 3 | Sensed mode-select pins |
| nconfig_pin_i | input | 1 | Sensed nconfig pin level |
| nstatus_pin_i | input | 1 | Sensed nstatus pin level |
| conf_done_pin_i | input | 1 | Sensed configuration-done pin level |
| pr_ready_i | input | 1 | Device ready for PR data |
| pr_done_i | input | 1 | Device finished PR |
| pr_error_i | input | 1 | Device reports PR error |
| usermode_i | input | 1 | Device in user mode |
| data_end_i | input | 1 | Payload streaming finished |
| nce_o | output | 1 | Chip enable, active low |
| pr_request_o | output | 1 | PR request to the device |
| path_en_o | output | 1 | Configuration clock and data path enable |
| override_o | output | 1 | Port override claimed |
| dclk_o | output | 1 | Configuration clock pulse |
| busy_o | output | 1 | Session or report in progress |
| done_o | output | 1 | One-cycle report pulse |
| result_o | output | 2 | 0 ok, 1 invalid, 2 error, 3 timeout |

## Verification
The reference model follows each session cycle by cycle. The bench drives a set of start conditions that separate the screening paths. These are a full-configuration request, a bad mode code, and each status pin low, against both accepted mode codes. It also varies the handshake inputs so that each exit of both polls is taken: error and ready together show the error priority, a silent ready line shows the poll budget, and a late error shows that streaming ignores the error input while the done poll acts on it. Final-status failures after a clean run, and after an abort, separate the timeout code from a kept error code. Pulse totals, counted with the request high and with it low, confirm the burst lengths on both sides of the request.

// File: rtl/prseq_pkg.sv
package prseq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FLUSH_IN, ST_REQ_BURST, ST_WAIT_RDY, ST_STREAM, ST_WAIT_DONE,
    ST_FLUSH_OUT, ST_PATH_OFF, ST_NCE_OFF, ST_CHECK, ST_REPORT
  } state_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_INVALID = 2'd1,
    RES_ERROR   = 2'd2,
    RES_TIMEOUT = 2'd3
  } result_e;
endpackage

// File: rtl/prseq_burst.sv
module prseq_burst #(
  parameter int CNT_W = 12,
  parameter int DIV   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clr_i,
  output logic             dclk_o,
  output logic             done_o
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [CNT_W-1:0] rem_q;
  logic [PH_W-1:0]  ph_q;
  logic             flag_q;

  // go clears the flag and loads; the flag sets as the last pulse period ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      ph_q   <= '0;
      flag_q <= 1'b0;
    end else if (go_i) begin
      rem_q  <= count_i;
      ph_q   <= '0;
      flag_q <= 1'b0;
    end else if (rem_q != '0) begin
      if (ph_q == PH_LAST) begin
        ph_q  <= '0;
        rem_q <= rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) flag_q <= 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign dclk_o = (rem_q != '0) && (ph_q == '0);
  assign done_o = flag_q;

  // checker: pulses seen since load must equal the loaded count
  logic [CNT_W:0]   pulses_q;
  logic [CNT_W-1:0] load_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulses_q <= '0;
      load_q   <= '0;
    end else if (go_i) begin
      pulses_q <= '0;
      load_q   <= count_i;
    end else if (dclk_o) begin
      pulses_q <= pulses_q + 1'b1;
    end
  end

  p_pulse_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (pulses_q == {1'b0, load_q}));
endmodule

// File: rtl/prseq_poll.sv
module prseq_poll #(
  parameter int POLL_MAX = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(POLL_MAX - 1));

  p_poll_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(POLL_MAX));
endmodule

// File: rtl/prseq_top.sv
module prseq_top
  import prseq_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int DIV        = 2,
  parameter int FLUSH_CLKS = 256,
  parameter int REQ_CLKS   = 2047,
  parameter int POLL_MAX   = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic [2:0] msel_i,
  input  logic       nconfig_pin_i,
  input  logic       nstatus_pin_i,
  input  logic       conf_done_pin_i,
  input  logic       pr_ready_i,
  input  logic       pr_done_i,
  input  logic       pr_error_i,
  input  logic       usermode_i,
  input  logic       data_end_i,
  output logic       nce_o,
  output logic       pr_request_o,
  output logic       path_en_o,
  output logic       override_o,
  output logic       dclk_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] result_o
);
  state_e  state_q, state_d;
  result_e pend_q, pend_d, res_q, res_d;
  logic    go, burst_done, poll_clr, poll_inc, poll_last;
  logic [CNT_W-1:0] burst_cnt;

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    res_d    = res_q;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        pend_d = RES_OK;
        if (!partial_i || (msel_i > 3'd1) || !nconfig_pin_i || !nstatus_pin_i) begin
          res_d   = RES_INVALID;
          state_d = ST_REPORT;
        end else begin
          state_d = ST_FLUSH_IN;
        end
      end
      ST_FLUSH_IN:  if (burst_done) state_d = ST_REQ_BURST;
      ST_REQ_BURST: if (burst_done) begin
        state_d  = ST_WAIT_RDY;
        poll_clr = 1'b1;
      end
      ST_WAIT_RDY: begin
        if (pr_error_i) begin
          pend_d  = RES_ERROR;
          state_d = ST_FLUSH_OUT;
        end else if (pr_ready_i) begin
          state_d = ST_STREAM;
        end else if (poll_last) begin
          pend_d  = RES_TIMEOUT;
          state_d = ST_FLUSH_OUT;
        end else begin
          poll_inc = 1'b1;
        end
      end
      ST_STREAM: if (data_end_i) begin
        state_d  = ST_WAIT_DONE;
        poll_clr = 1'b1;
      end
      ST_WAIT_DONE: begin
        if (pr_error_i) begin
          pend_d  = RES_ERROR;
          state_d = ST_FLUSH_OUT;
        end else if (pr_done_i) begin
          state_d = ST_FLUSH_OUT;
        end else if (poll_last) begin
          pend_d  = RES_TIMEOUT;
          state_d = ST_FLUSH_OUT;
        end else begin
          poll_inc = 1'b1;
        end
      end
      ST_FLUSH_OUT: if (burst_done) state_d = ST_PATH_OFF;
      ST_PATH_OFF:  state_d = ST_NCE_OFF;
      ST_NCE_OFF:   state_d = ST_CHECK;
      ST_CHECK: begin
        if (pend_q == RES_OK && !(usermode_i && conf_done_pin_i && nstatus_pin_i))
          res_d = RES_TIMEOUT;
        else
          res_d = pend_q;
        state_d = ST_REPORT;
      end
      ST_REPORT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // a burst is launched on the edge that enters a burst state
  assign go = (state_d != state_q) &&
              (state_d inside {ST_FLUSH_IN, ST_REQ_BURST, ST_FLUSH_OUT});
  assign burst_cnt = (state_d == ST_REQ_BURST) ? CNT_W'(REQ_CLKS) : CNT_W'(FLUSH_CLKS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= RES_OK;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      res_q   <= res_d;
    end
  end

  prseq_burst #(.CNT_W(CNT_W), .DIV(DIV)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .count_i (burst_cnt),
    .clr_i   (burst_done),
    .dclk_o  (dclk_o),
    .done_o  (burst_done)
  );

  prseq_poll #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  assign nce_o        = !(state_q inside {ST_FLUSH_IN, ST_REQ_BURST, ST_WAIT_RDY, ST_STREAM,
                                          ST_WAIT_DONE, ST_FLUSH_OUT, ST_PATH_OFF});
  assign path_en_o    = state_q inside {ST_FLUSH_IN, ST_REQ_BURST, ST_WAIT_RDY, ST_STREAM,
                                        ST_WAIT_DONE, ST_FLUSH_OUT};
  assign override_o   = state_q inside {ST_FLUSH_IN, ST_REQ_BURST, ST_WAIT_RDY, ST_STREAM,
                                        ST_WAIT_DONE, ST_FLUSH_OUT, ST_PATH_OFF, ST_NCE_OFF};
  assign pr_request_o = state_q inside {ST_REQ_BURST, ST_WAIT_RDY, ST_STREAM, ST_WAIT_DONE};
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_REPORT);
  assign result_o     = res_q;

  p_dclk_in_path_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_o |-> path_en_o);
  p_go_when_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |-> !dclk_o);
  p_req_setup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pr_request_o) |-> (!nce_o && path_en_o && override_o));
  p_path_off_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(path_en_o) |-> (!pr_request_o && !nce_o && override_o));
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);
endmodule

// File: tb/prseq_top_test.sv
module prseq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int FLUSH = 256;
  localparam int REQC  = 2047;
  localparam int POLL  = 10;

  logic clk, rst_ni;
  logic start_i, partial_i, nconfig_pin_i, nstatus_pin_i, conf_done_pin_i;
  logic pr_ready_i, pr_done_i, pr_error_i, usermode_i, data_end_i;
  logic [2:0] msel_i;
  logic nce_o, pr_request_o, path_en_o, override_o, dclk_o, busy_o, done_o;
  logic [1:0] result_o;

  prseq_top #(.CNT_W(12), .DIV(DIV), .FLUSH_CLKS(FLUSH), .REQ_CLKS(REQC), .POLL_MAX(POLL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .partial_i(partial_i), .msel_i(msel_i),
    .nconfig_pin_i(nconfig_pin_i), .nstatus_pin_i(nstatus_pin_i),
    .conf_done_pin_i(conf_done_pin_i), .pr_ready_i(pr_ready_i), .pr_done_i(pr_done_i),
    .pr_error_i(pr_error_i), .usermode_i(usermode_i), .data_end_i(data_end_i),
    .nce_o(nce_o), .pr_request_o(pr_request_o), .path_en_o(path_en_o),
    .override_o(override_o), .dclk_o(dclk_o), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o)
  );

  int checks = 0, fails = 0;
  int n_req = 0, n_low = 0;
  bit model_on = 0;
  logic e_nce, e_req, e_path, e_ovr, e_dclk, e_busy, e_done;
  logic [1:0] e_res;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  task automatic m_burst(input int n);
    for (int p = 0; p < n; p++)
      for (int ph = 0; ph < DIV; ph++) begin
        e_dclk = (ph == 0);
        @(posedge clk);
      end
    e_dclk = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    int code;
    e_res = 2'd0;
    wait (rst_ni === 1'b1);
    model_on = 1'b1;
    forever begin
      e_nce = 1; e_req = 0; e_path = 0; e_ovr = 0; e_dclk = 0; e_busy = 0; e_done = 0;
      do @(posedge clk); while (!start_i);
      if (!partial_i || msel_i > 3'd1 || !nconfig_pin_i || !nstatus_pin_i) begin
        e_busy = 1; e_done = 1; e_res = 2'd1;
        @(posedge clk);
        continue;
      end
      code = 0;
      e_busy = 1; e_nce = 0; e_path = 1; e_ovr = 1; e_req = 0;
      m_burst(FLUSH);
      e_req = 1;
      m_burst(REQC);
      for (int i = 0; i < POLL; i++) begin
        @(posedge clk);
        if (pr_error_i) begin code = 2; break; end
        if (pr_ready_i) break;
        if (i == POLL - 1) code = 3;
      end
      if (code == 0) begin
        do @(posedge clk); while (!data_end_i);
        for (int i = 0; i < POLL; i++) begin
          @(posedge clk);
          if (pr_error_i) begin code = 2; break; end
          if (pr_done_i) break;
          if (i == POLL - 1) code = 3;
        end
      end
      e_req = 0;
      m_burst(FLUSH);
      e_path = 0;
      @(posedge clk);
      e_nce = 1;
      @(posedge clk);
      e_ovr = 0;
      @(posedge clk);
      if (code == 0 && !(usermode_i && conf_done_pin_i && nstatus_pin_i)) code = 3;
      e_done = 1; e_res = 2'(code);
      @(posedge clk);
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_ni && model_on) begin
      check(nce_o === e_nce,        "R4 nce",        nce_o,        e_nce);
      check(path_en_o === e_path,   "R4 path_en",    path_en_o,    e_path);
      check(override_o === e_ovr,   "R8 override",   override_o,   e_ovr);
      check(pr_request_o === e_req, "R5 pr_request", pr_request_o, e_req);
      check(dclk_o === e_dclk,      "R11 dclk",      dclk_o,       e_dclk);
      check(busy_o === e_busy,      "R10 busy",      busy_o,       e_busy);
      check(done_o === e_done,      "R10 done",      done_o,       e_done);
      check(result_o === e_res,     "R9 result",     result_o,     e_res);
      if (dclk_o) begin
        if (pr_request_o) n_req++;
        else n_low++;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic run(input string tag, input int exp, input bit full,
                     input bit part, input logic [2:0] ms, input bit ncfg, input bit nst,
                     input bit rdy, input bit err, input bit dend, input bit dn,
                     input bit um, input bit cd, input bit late_err, input bit poke);
    @(negedge clk);
    partial_i = part; msel_i = ms; nconfig_pin_i = ncfg; nstatus_pin_i = nst;
    pr_ready_i = rdy; pr_error_i = err; data_end_i = dend; pr_done_i = dn;
    usermode_i = um; conf_done_pin_i = cd;
    n_req = 0; n_low = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (!full) begin
      check(done_o === 1'b1 && result_o === 2'd1, {tag, " immediate reject"}, result_o, 1);
      check(nce_o === 1'b1 && !path_en_o && !override_o, {tag, " port untouched"}, nce_o, 1);
    end
    if (poke) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1; partial_i = 1'b0;  // R11: must be ignored mid-session
      @(negedge clk);
      start_i = 1'b0; partial_i = 1'b1;
    end
    if (late_err) begin
      while (!pr_request_o) @(negedge clk);
      repeat (REQC * DIV + 5) @(negedge clk);
      pr_error_i = 1'b1; data_end_i = 1'b1;
    end
    while (!done_o) @(negedge clk);
    check(result_o === 2'(exp), {tag, " result"}, result_o, exp);
    if (full) begin
      check(n_req == REQC, {tag, " R5 pulses with request"}, n_req, REQC);
      check(n_low == 2 * FLUSH, {tag, " R4 R8 flush pulses"}, n_low, 2 * FLUSH);
    end else begin
      check(n_req + n_low == 0, {tag, " no pulses"}, n_req + n_low, 0);
    end
    @(negedge clk);
    check(!busy_o && !done_o, {tag, " R10 back idle"}, busy_o, 0);
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 0; partial_i = 1; msel_i = 3'd0; nconfig_pin_i = 1;
    nstatus_pin_i = 1; conf_done_pin_i = 1; pr_ready_i = 1; pr_done_i = 1; pr_error_i = 0;
    usermode_i = 1; data_end_i = 1;
    repeat (3) @(negedge clk);
    check(nce_o === 1'b1, "R10 reset nce", nce_o, 1);
    check({pr_request_o, path_en_o, override_o, dclk_o, busy_o, done_o} === 6'b0,
          "R10 reset outputs", {pr_request_o, path_en_o, override_o, dclk_o, busy_o, done_o}, 0);
    check(result_o === 2'd0, "R10 reset result", result_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    //  tag             exp full part msel  ncfg nst rdy err dend dn um cd late poke
    run("R1 full cfg",   1, 0, 0, 3'b000, 1, 1, 1, 0, 1, 1, 1, 1, 0, 0);
    run("R2 bad msel",   1, 0, 1, 3'b010, 1, 1, 1, 0, 1, 1, 1, 1, 0, 0);
    run("R3 nstatus lo", 1, 0, 1, 3'b000, 1, 0, 1, 0, 1, 1, 1, 1, 0, 0);
    run("R3 nconfig lo", 1, 0, 1, 3'b000, 0, 1, 1, 0, 1, 1, 1, 1, 0, 0);
    run("R9 R11 ok",     0, 1, 1, 3'b000, 1, 1, 1, 0, 1, 1, 1, 1, 0, 1);
    run("R2 msel 001",   0, 1, 1, 3'b001, 1, 1, 1, 0, 1, 1, 1, 1, 0, 0);
    run("R6 err prio",   2, 1, 1, 3'b000, 1, 1, 1, 1, 1, 1, 0, 1, 0, 0);
    run("R6 rdy tmo",    3, 1, 1, 3'b000, 1, 1, 0, 0, 1, 1, 1, 1, 0, 0);
    run("R7 done err",   2, 1, 1, 3'b000, 1, 1, 1, 0, 0, 0, 1, 1, 1, 0);
    run("R7 done tmo",   3, 1, 1, 3'b000, 1, 1, 1, 0, 1, 0, 1, 1, 0, 0);
    run("R9 no user",    3, 1, 1, 3'b000, 1, 1, 1, 0, 1, 1, 0, 1, 0, 0);
    run("R9 no cdone",   3, 1, 1, 3'b000, 1, 1, 1, 0, 1, 1, 1, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule